// File: doc/BRIEF.md
# Virtqueue Doorbell Notification Decoder

This block watches driver writes into a notification window and turns each valid one into a single-cycle doorbell pulse for one virtqueue. Every queue has a programmable notify offset. The block derives that queue's doorbell address as the offset scaled by a fixed byte multiplier, plus a fixed base. The multiplier is zero or an even power of two. It is set at build time as a left shift. Any shift below one selects the zero multiplier, which puts every queue on the base address.

A notification is a 16-bit write whose data carries the queue index. Several queues may share one doorbell address, so the address only qualifies a write and the data picks the queue. A write is accepted only when all of these hold:

- the index names an existing queue;
- that queue is enabled;
- the address equals the doorbell address computed for that queue.

Any other write raises a single-cycle error strobe instead. Both outputs are registered and appear on the clock edge after the write.

Top module: `vq_doorbell_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, every doorbell output and the error strobe are low.
- R2: A write whose data is queue index q (q below NUM_Q), whose queue q is enabled, and whose address equals BASE_OFF + notify_off[q] * 2^NOTIFY_SHIFT raises doorbell bit q. The bit rises on the next clock edge, stays high for exactly one cycle, and the error strobe stays low.
- R3: A write whose address differs from the computed doorbell address of the queue named in its data raises the error strobe for one cycle and raises no doorbell bit.
- R4: A write whose 16-bit data is NUM_Q or larger raises the error strobe for one cycle and raises no doorbell bit.
- R5: A write naming a queue whose enable input is low raises the error strobe for one cycle and raises no doorbell bit.
- R6: When two queues share a notify offset, a write to that shared address signals only the queue named in the data.
- R7: With NOTIFY_SHIFT below 1 the multiplier is zero: every queue's doorbell address is BASE_OFF whatever its notify offset, and a write elsewhere raises the error strobe.
- R8: In any cycle at most one doorbell bit is high, and the error strobe is never high together with a doorbell bit.
- R9: A cycle without a write strobe produces no doorbell and no error in the following cycle. Back-to-back writes each produce their own result in consecutive cycles.
- R10: The notify offsets and enables are sampled in the cycle of the write, so a change to them governs the very next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe into the notification window |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 16 | Written data: the virtqueue index |
| q_notify_off | input | NUM_Q*OFF_W | Notify offset of each queue, queue i at bits [i*OFF_W +: OFF_W] |
| q_enable | input | NUM_Q | Per-queue enable, bit i for queue i |
| doorbell | output | NUM_Q | One-cycle notify pulse, bit i for queue i |
| notify_err | output | 1 | One-cycle strobe for a rejected write |

## Verification
A doorbell pulse from one write and the verdict on the next write both come from the same output register. Back-to-back writes therefore make a pulse for one queue land in the cycle right after the pulse or error of the previous write. The bench provokes this by issuing an accepted write, a mismatched write and another accepted write to a different queue on consecutive clocks. It judges each output cycle on its own: the right single bit or the error strobe, never both together and never a leftover pulse. A shared-address write is also placed next to a change of notify offset. This shows that the offset in force during the write cycle decides the outcome.

// File: rtl/vqdb_pkg.sv
// Package: shared helpers for the doorbell decoder.
// Assumes: addresses and offsets fit in 32 bits before truncation.
package vqdb_pkg;

    // Doorbell byte address for one queue; shift below 1 means multiplier zero.
    function automatic logic [31:0] slot_address(
        input logic [31:0] base,
        input logic [31:0] notify_off,
        input int          shift
    );
        logic [31:0] scaled;
        scaled = (shift < 1) ? 32'd0 : (notify_off << shift);
        return base + scaled;
    endfunction

endpackage

// File: rtl/vqdb_addr_map.sv
// Module: vqdb_addr_map
// Computes the doorbell address of every queue from its notify offset.
// Assumes: NOTIFY_SHIFT is fixed at build time; any value below 1 selects
// the zero multiplier, so every queue sits on BASE_OFF.
module vqdb_addr_map #(
    parameter int NUM_Q        = 8,
    parameter int OFF_W        = 8,
    parameter int ADDR_W       = 12,
    parameter int NOTIFY_SHIFT = 2,
    parameter int unsigned BASE_OFF = 32'h100
) (
    input  logic [NUM_Q*OFF_W-1:0]  q_notify_off,
    output logic [NUM_Q*ADDR_W-1:0] slot_addr
);
    import vqdb_pkg::*;

    localparam bit ZERO_MULT = (NOTIFY_SHIFT < 1);

    for (genvar i = 0; i < NUM_Q; i++) begin : g_slot
        if (ZERO_MULT) begin : g_zero
            // Zero multiplier: every queue shares the base address.
            assign slot_addr[i*ADDR_W +: ADDR_W] = ADDR_W'(BASE_OFF);
        end else begin : g_shift
            logic [31:0] full_addr;
            // Scale offset by shifting, then add the base.
            always_comb begin
                full_addr = slot_address(BASE_OFF,
                                         32'(q_notify_off[i*OFF_W +: OFF_W]),
                                         NOTIFY_SHIFT);
            end
            assign slot_addr[i*ADDR_W +: ADDR_W] = full_addr[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/vqdb_req_check.sv
// Module: vqdb_req_check
// Judges one write: picks the queue named in the data and checks range,
// enable and address against that queue's doorbell slot.
// Assumes: one write per cycle; inputs are stable around the clock edge.
module vqdb_req_check #(
    parameter int NUM_Q  = 8,
    parameter int ADDR_W = 12,
    localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [15:0]             wr_data,
    input  logic [NUM_Q*ADDR_W-1:0] slot_addr,
    input  logic [NUM_Q-1:0]        q_enable,
    output logic                    accept,
    output logic                    reject,
    output logic [IDX_W-1:0]        accept_idx
);
    logic             in_range;
    logic [IDX_W-1:0] idx;
    logic [ADDR_W-1:0] sel_addr;
    logic             sel_en;

    // Index bounds check on the full 16-bit data.
    always_comb begin
        in_range = (32'(wr_data) < NUM_Q);
        idx      = wr_data[IDX_W-1:0];
    end

    // Select the slot address and enable of the named queue.
    always_comb begin
        sel_addr = '0;
        sel_en   = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (idx == IDX_W'(i)) begin
                sel_addr = slot_addr[i*ADDR_W +: ADDR_W];
                sel_en   = q_enable[i];
            end
        end
    end

    // Final verdict for the write.
    always_comb begin
        accept     = wr_en && in_range && sel_en && (wr_addr == sel_addr);
        reject     = wr_en && !accept;
        accept_idx = idx;
    end
endmodule

// File: rtl/vqdb_pulse_reg.sv
// Module: vqdb_pulse_reg
// Registers the verdict into one-hot doorbell pulses and an error strobe.
// Assumes: accept and reject are never both high.
module vqdb_pulse_reg #(
    parameter int NUM_Q = 8,
    localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             reject,
    input  logic [IDX_W-1:0] accept_idx,
    output logic [NUM_Q-1:0] doorbell,
    output logic             notify_err
);
    for (genvar i = 0; i < NUM_Q; i++) begin : g_bell
        // One-cycle pulse for queue i on an accepted write naming it.
        always_ff @(posedge clk) begin
            if (!rst_n) doorbell[i] <= 1'b0;
            else        doorbell[i] <= accept && (accept_idx == IDX_W'(i));
        end
    end

    // One-cycle error strobe on a rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n) notify_err <= 1'b0;
        else        notify_err <= reject;
    end

    // R8: a registered pulse always traces back to an accept in the prior cycle.
    assert_pulse_from_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|doorbell) |-> $past(accept));
    // R8: error strobe traces back to a reject.
    assert_err_from_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        notify_err |-> $past(reject));
endmodule

// File: rtl/vq_doorbell_decoder.sv
// Module: vq_doorbell_decoder (top)
// Decodes 16-bit notification writes into per-queue doorbell pulses.
// Address qualifies the write; data names the queue. Outputs registered,
// one cycle after the write. Assumes BASE_OFF is even.
module vq_doorbell_decoder #(
    parameter int NUM_Q        = 8,
    parameter int OFF_W        = 8,
    parameter int ADDR_W       = 12,
    parameter int NOTIFY_SHIFT = 2,
    parameter int unsigned BASE_OFF = 32'h100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [15:0]            wr_data,
    input  logic [NUM_Q*OFF_W-1:0] q_notify_off,
    input  logic [NUM_Q-1:0]       q_enable,
    output logic [NUM_Q-1:0]       doorbell,
    output logic                   notify_err
);
    localparam int IDX_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    logic [NUM_Q*ADDR_W-1:0] slot_addr;
    logic                    accept;
    logic                    reject;
    logic [IDX_W-1:0]        accept_idx;

    vqdb_addr_map #(
        .NUM_Q(NUM_Q), .OFF_W(OFF_W), .ADDR_W(ADDR_W),
        .NOTIFY_SHIFT(NOTIFY_SHIFT), .BASE_OFF(BASE_OFF)
    ) u_map (
        .q_notify_off(q_notify_off),
        .slot_addr   (slot_addr)
    );

    vqdb_req_check #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_check (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .slot_addr (slot_addr),
        .q_enable  (q_enable),
        .accept    (accept),
        .reject    (reject),
        .accept_idx(accept_idx)
    );

    vqdb_pulse_reg #(.NUM_Q(NUM_Q)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .reject    (reject),
        .accept_idx(accept_idx),
        .doorbell  (doorbell),
        .notify_err(notify_err)
    );

    // R8: at most one queue signalled per cycle.
    assert_onehot_bell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(doorbell));
    // R8: error and doorbell never together.
    assert_no_err_with_bell_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(notify_err && (|doorbell)));
    // R9: no write strobe means a quiet next cycle.
    assert_quiet_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (doorbell == '0) && !notify_err);
    // R4: an out-of-range index never rings a bell.
    assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_data) >= NUM_Q)) |=> (doorbell == '0) && notify_err);

    for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
        // R5: a bell only for a queue that was enabled at write time.
        assert_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
            doorbell[i] |-> $past(q_enable[i]) && $past(wr_data) == 16'(i));
    end
endmodule

// File: tb/tb_vq_doorbell_decoder.sv
module tb_vq_doorbell_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NQ  = 8;
    localparam int OW  = 8;
    localparam int AW  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [NQ*OW-1:0] q_off;
    logic [NQ-1:0] q_en;
    logic [NQ-1:0] bell, bell_z;
    logic err, err_z;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vq_doorbell_decoder #(.NUM_Q(NQ), .OFF_W(OW), .ADDR_W(AW),
        .NOTIFY_SHIFT(2), .BASE_OFF(32'h100)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .q_notify_off(q_off), .q_enable(q_en),
        .doorbell(bell), .notify_err(err));

    vq_doorbell_decoder #(.NUM_Q(NQ), .OFF_W(OW), .ADDR_W(AW),
        .NOTIFY_SHIFT(-1), .BASE_OFF(32'h100)) dut_zero (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .q_notify_off(q_off), .q_enable(q_en),
        .doorbell(bell_z), .notify_err(err_z));

    // Doorbell address per requirement R2: base 0x100 plus offset times 4.
    function automatic logic [AW-1:0] exp_addr(input int off);
        return AW'(32'h100 + off * 4);
    endfunction

    task automatic check(input string req, input logic [NQ:0] got, input logic [NQ:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got bell/err=%b expected %b", req, got, exp);
        end
    endtask

    // Issue one write at a falling edge; result is sampled one cycle later.
    task automatic drive(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic single(input string req, input logic [AW-1:0] a, input logic [15:0] d,
                          input logic [NQ:0] exp);
        drive(a, d);
        idle();
        check(req, {err, bell}, exp);
        @(negedge clk);
        check({req, " one-cycle"}, {err, bell}, '0);
    endtask

    task automatic t_reset();
        check("R1 reset", {err, bell}, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {err, bell}, '0);
    endtask

    task automatic t_accept();
        single("R2 q0", exp_addr(0), 16'd0, {1'b0, 8'b0000_0001});
        single("R2 q7", exp_addr(7), 16'd7, {1'b0, 8'b1000_0000});
        single("R2 q2", exp_addr(2), 16'd2, {1'b0, 8'b0000_0100});
    endtask

    task automatic t_reject();
        single("R3 wrong addr", exp_addr(3), 16'd2, {1'b1, 8'h00});
        single("R3 addr+2", exp_addr(1) + 2, 16'd1, {1'b1, 8'h00});
        single("R4 idx=NUM_Q", exp_addr(0), 16'd8, {1'b1, 8'h00});
        single("R4 idx high bits", exp_addr(1), 16'h8001, {1'b1, 8'h00});
        single("R5 disabled q6", exp_addr(6), 16'd6, {1'b1, 8'h00});
    endtask

    task automatic t_shared_and_update();
        // R10: queue 5 moved onto offset 3; takes effect at the next write.
        @(negedge clk); q_off[5*OW +: OW] = 8'd3;
        single("R6 shared q5", exp_addr(3), 16'd5, {1'b0, 8'b0010_0000});
        single("R6 shared q3", exp_addr(3), 16'd3, {1'b0, 8'b0000_1000});
        single("R10 old q5 addr", exp_addr(5), 16'd5, {1'b1, 8'h00});
        // R10: re-enable queue 6 and it is accepted at once.
        @(negedge clk); q_en[6] = 1'b1;
        single("R10 q6 enabled", exp_addr(6), 16'd6, {1'b0, 8'b0100_0000});
    endtask

    task automatic t_zero_mult();
        drive(AW'(12'h100), 16'd4);
        idle();
        check("R7 zero mult q4", {err_z, bell_z}, {1'b0, 8'b0001_0000});
        check("R3 scaled dut q4 at base", {err, bell}, {1'b1, 8'h00});
        drive(exp_addr(4), 16'd4);
        idle();
        check("R7 zero mult off-base", {err_z, bell_z}, {1'b1, 8'h00});
    endtask

    task automatic t_back_to_back();
        drive(exp_addr(1), 16'd1);
        drive(exp_addr(1), 16'd2);
        check("R9 b2b first", {err, bell}, {1'b0, 8'b0000_0010});
        drive(exp_addr(4), 16'd4);
        check("R9 b2b second", {err, bell}, {1'b1, 8'h00});
        idle();
        check("R9 b2b third", {err, bell}, {1'b0, 8'b0001_0000});
        @(negedge clk);
        check("R9 idle", {err, bell}, '0);
    endtask

    initial begin
        for (int i = 0; i < NQ; i++) q_off[i*OW +: OW] = OW'(i);
        q_en = 8'b1011_1111;
        @(negedge clk);
        t_reset();
        t_accept();
        t_reject();
        t_shared_and_update();
        t_zero_mult();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule